// File: doc/BRIEF.md
# Addressed Output Latch and Bidirectional GPIO

This block sits behind a parallel-port protocol engine. The engine latches a channel address from a command cycle and then sends write strobes and read-request strobes. The block decodes that address into three register functions.

The first function builds a 16-bit output word from two byte writes and then pulses an active-low chip select. The second function is a per-bit direction register. The third is an 8-bit general-purpose port. Writes to this port drive only the pins marked as outputs. Reads return the live pin levels after a two-flop synchronizer.

The pins are brought out in the form a pad ring expects. Each pin has a data-out bit, an output-enable bit and a data-in bit, and the tristate buffer lives in the pad cell.

Top module: `addr_out_gpio`

## Requirements
- R1: After reset, word_o is 0x0000, cs_no is high, gpio_oe_o and gpio_out_o are 0x00, and rdata_o is 0x00. With all enables at 0, every GPIO pin is tristated.
- R2: A first write strobe at address 0x00 leaves word_o unchanged. The next write at 0x00 loads word_o with the first byte in bits 15:8 and the second byte in bits 7:0. The new word is visible after the clock edge that samples the second strobe.
- R3: cs_no goes low one clock after word_o updates. It stays low for exactly 4 clocks and then returns high.
- R4: A write or read strobe at any address other than 0x00 discards a pending first byte. The next write at 0x00 is then treated as a first byte again.
- R5: A write at address 0x02 loads gpio_oe_o with the data byte, one bit per pin. A bit value of 1 means output and 0 means input.
- R6: A write at address 0x03 loads gpio_out_o. A pin is driven only when its enable bit is 1; pins whose enable bit is 0 stay undriven.
- R7: A read strobe at address 0x03 returns the synchronized state of all 8 pins on rdata_o one clock later. This includes pins the block drives itself. A pin change is visible to reads within 3 clocks.
- R8: A read strobe at any address other than 0x03 returns 0x00 on rdata_o one clock later.
- R9: Write strobes at addresses 0x01 and at any address above 0x03 change none of word_o, gpio_oe_o or gpio_out_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Channel address latched by the protocol engine |
| wdata_i | input | 8 | Write data byte |
| wr_i | input | 1 | Write strobe, one clock per byte |
| rd_i | input | 1 | Read-request strobe, one clock per byte |
| rdata_o | output | 8 | Read data, registered and held until the next read |
| word_o | output | 16 | Parallel output word |
| cs_no | output | 1 | Chip-select pulse, active low |
| gpio_out_o | output | 8 | GPIO pad data out |
| gpio_oe_o | output | 8 | GPIO pad output enable, 1 drives the pin |
| gpio_in_i | input | 8 | GPIO pad data in (live pin level) |

## Verification
Each stimulus is applied at a falling edge. Word, enable and data-out results are due at the falling edge right after the rising edge that samples the strobe. Chip select stays high at that sample, is low at the next four falling edges and is high again at the fifth; the bench samples each of those cycles.

Read data is due one clock after the read strobe. Before any read, the bench waits three clocks after changing external pin levels so the value has passed the synchronizer. Random sequences of writes, reads and pin changes are checked against a bench model of the pad resolution and the pending-byte rule. Directed cases cover an interrupted byte pair and writes to unused addresses.

// File: rtl/addr_out_gpio_pkg.sv
package addr_out_gpio_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;
  localparam logic [ADDR_W-1:0] ADR_WORD = 7'h00;
  localparam logic [ADDR_W-1:0] ADR_DIR  = 7'h02;
  localparam logic [ADDR_W-1:0] ADR_PORT = 7'h03;
endpackage

// File: rtl/aog_sync.sv
module aog_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[b] <= '0;
      else         chain[b] <= {chain[b][STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/aog_word_out.sv
module aog_word_out #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CS_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,    // write strobe at word address
  input  logic              other_i,  // any strobe elsewhere
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [2*BYTE_W-1:0] word_o,
  output logic              cs_no,
  output logic              ld_o
);
  localparam int unsigned CNT_W = $clog2(CS_LEN + 1);

  logic              second_q;
  logic [BYTE_W-1:0] hold_q;
  logic              ld_q;
  logic [CNT_W-1:0]  cs_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q <= 1'b0;
      hold_q   <= '0;
      word_o   <= '0;
      ld_q     <= 1'b0;
    end else begin
      ld_q <= 1'b0;
      if (other_i) begin
        second_q <= 1'b0;
      end else if (sel_i) begin
        if (!second_q) begin
          hold_q   <= wdata_i;
          second_q <= 1'b1;
        end else begin
          word_o   <= {hold_q, wdata_i};
          second_q <= 1'b0;
          ld_q     <= 1'b1;
        end
      end
    end
  end

  // pulse starts the clock after the word update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cs_cnt_q <= '0;
    else if (ld_q)              cs_cnt_q <= CNT_W'(CS_LEN);
    else if (cs_cnt_q != '0)    cs_cnt_q <= cs_cnt_q - 1'b1;
  end

  assign cs_no = (cs_cnt_q == '0);
  assign ld_o  = ld_q;
endmodule

// File: rtl/aog_gpio.sv
module aog_gpio #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_wr_i,
  input  logic              port_wr_i,
  input  logic              rd_i,
  input  logic              port_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [BYTE_W-1:0] pin_sync_i,
  output logic [BYTE_W-1:0] oe_o,
  output logic [BYTE_W-1:0] out_o,
  output logic [BYTE_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= '0;
      out_o   <= '0;
      rdata_o <= '0;
    end else begin
      if (dir_wr_i)  oe_o  <= wdata_i;
      if (port_wr_i) out_o <= wdata_i;
      if (rd_i)      rdata_o <= port_rd_i ? pin_sync_i : '0;
    end
  end
endmodule

// File: rtl/addr_out_gpio.sv
module addr_out_gpio
  import addr_out_gpio_pkg::*;
#(
  parameter int unsigned CS_LEN  = 4,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [2*BYTE_W-1:0] word_o,
  output logic              cs_no,
  output logic [BYTE_W-1:0] gpio_out_o,
  output logic [BYTE_W-1:0] gpio_oe_o,
  input  logic [BYTE_W-1:0] gpio_in_i
);
  logic hit_word, hit_dir, hit_port;
  logic word_ld;
  logic [BYTE_W-1:0] pin_sync;

  assign hit_word = (addr_i == ADR_WORD);
  assign hit_dir  = (addr_i == ADR_DIR);
  assign hit_port = (addr_i == ADR_PORT);

  aog_word_out #(.BYTE_W(BYTE_W), .CS_LEN(CS_LEN)) u_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (wr_i && hit_word),
    .other_i ((wr_i || rd_i) && !hit_word),
    .wdata_i (wdata_i),
    .word_o  (word_o),
    .cs_no   (cs_no),
    .ld_o    (word_ld)
  );

  aog_sync #(.WIDTH(BYTE_W), .STAGES(SYNC_ST)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gpio_in_i),
    .q_o    (pin_sync)
  );

  aog_gpio #(.BYTE_W(BYTE_W)) u_gpio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dir_wr_i   (wr_i && hit_dir),
    .port_wr_i  (wr_i && hit_port),
    .rd_i       (rd_i),
    .port_rd_i  (hit_port),
    .wdata_i    (wdata_i),
    .pin_sync_i (pin_sync),
    .oe_o       (gpio_oe_o),
    .out_o      (gpio_out_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/addr_out_gpio_chk.sv
module addr_out_gpio_chk
  import addr_out_gpio_pkg::*;
#(
  parameter int unsigned CS_LEN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [2*BYTE_W-1:0] word_o,
  input logic              cs_no,
  input logic [BYTE_W-1:0] gpio_oe_o,
  input logic [BYTE_W-1:0] gpio_out_o,
  input logic [BYTE_W-1:0] rdata_o,
  input logic              word_ld
);
  logic [7:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              low_cnt <= '0;
    else if (cs_no)           low_cnt <= '0;
    else if (low_cnt != 8'hff) low_cnt <= low_cnt + 1'b1;
  end

  // R2
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADR_WORD) |=> $stable(word_o));
  // R3
  cs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ld |=> !cs_no);
  // R3
  cs_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (low_cnt >= 8'(CS_LEN)));
  // R5
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADR_DIR) |=> $stable(gpio_oe_o));
  // R6
  port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == ADR_PORT) |=> $stable(gpio_out_o));
  // R8
  rd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i != ADR_PORT) |=> (rdata_o == '0));
endmodule

bind addr_out_gpio addr_out_gpio_chk #(.CS_LEN(CS_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .word_o     (word_o),
  .cs_no      (cs_no),
  .gpio_oe_o  (gpio_oe_o),
  .gpio_out_o (gpio_out_o),
  .rdata_o    (rdata_o),
  .word_ld    (word_ld)
);

// File: tb/tb_addr_out_gpio.sv
module tb_addr_out_gpio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rdata, pout, poe, pin, ext = 8'h00;
  logic [15:0] word;
  logic        cs_n;

  int runs = 0, fails = 0;
  logic [15:0] m_word = '0;
  logic [7:0]  m_hold = '0, m_dir = '0, m_dat = '0;
  logic        m_pend = 1'b0;

  always #2.5 clk = ~clk;

  // pad model: enabled pins carry the driven value
  assign pin = (poe & pout) | (~poe & ext);

  addr_out_gpio dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .word_o(word), .cs_no(cs_n),
    .gpio_out_o(pout), .gpio_oe_o(poe), .gpio_in_i(pin)
  );

  function automatic logic [7:0] exp_pins(logic [7:0] d, logic [7:0] o, logic [7:0] e);
    return (d & o) | (~d & e);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [6:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (a == 7'h00) begin
      if (m_pend) begin m_word = {m_hold, d}; m_pend = 1'b0; end
      else        begin m_hold = d; m_pend = 1'b1; end
    end else m_pend = 1'b0;
    if (a == 7'h02) m_dir = d;
    if (a == 7'h03) m_dat = d;
  endtask

  task automatic rd_byte(logic [6:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
    if (a != 7'h00) m_pend = 1'b0;
    v = rdata;
  endtask

  task automatic word_pair(logic [7:0] hi, logic [7:0] lo);
    wr_byte(7'h00, hi);
    chk("R2 first byte holds word", 32'(word), 32'(m_word));
    wr_byte(7'h00, lo);
    chk("R2 word update", 32'(word), {16'h0, hi, lo});
    chk("R3 cs high at update", 32'(cs_n), 32'd1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 cs low", 32'(cs_n), 32'd0);
    end
    @(negedge clk);
    chk("R3 cs released", 32'(cs_n), 32'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 word", 32'(word), 32'h0);
    chk("R1 cs", 32'(cs_n), 32'd1);
    chk("R1 oe", 32'(poe), 32'h0);
    chk("R1 out", 32'(pout), 32'h0);
    chk("R1 rdata", 32'(rdata), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    word_pair(8'hA5, 8'h3C);
    word_pair(8'hFF, 8'h00);

    // R4 interrupted pair
    wr_byte(7'h00, 8'h11);
    wr_byte(7'h01, 8'h99);
    chk("R9 unused addr no effect", 32'(word), 32'(m_word));
    wr_byte(7'h00, 8'h22);
    chk("R4 pending dropped", 32'(word), 32'(m_word));
    wr_byte(7'h00, 8'h33);
    chk("R4 new pair", 32'(word), 32'h2233);
    repeat (6) @(negedge clk);
    wr_byte(7'h00, 8'h44);
    rd_byte(7'h05, v);
    chk("R8 other read zero", 32'(v), 32'h0);
    wr_byte(7'h00, 8'h55);
    chk("R4 read drops pending", 32'(word), 32'h2233);
    m_pend = 1'b0; wr_byte(7'h01, 8'h00);

    // R5 R6 R7 directed
    ext = 8'hC3;
    wr_byte(7'h02, 8'h0F);
    chk("R5 oe", 32'(poe), 32'h0F);
    wr_byte(7'h03, 8'h5A);
    chk("R6 out", 32'(pout), 32'h5A);
    chk("R6 undriven mask", 32'(poe & 8'hF0), 32'h0);
    repeat (3) @(negedge clk);
    rd_byte(7'h03, v);
    chk("R7 pin read", 32'(v), 32'(exp_pins(m_dir, m_dat, ext)));
    wr_byte(7'h7F, 8'hFF);
    wr_byte(7'h04, 8'h00);
    chk("R9 oe kept", 32'(poe), 32'(m_dir));
    chk("R9 out kept", 32'(pout), 32'(m_dat));
    chk("R9 word kept", 32'(word), 32'(m_word));

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: word_pair(8'($urandom), 8'($urandom));
        1: begin wr_byte(7'h02, 8'($urandom)); chk("R5 oe rand", 32'(poe), 32'(m_dir)); end
        2: begin wr_byte(7'h03, 8'($urandom)); chk("R6 out rand", 32'(pout), 32'(m_dat)); end
        3: begin ext = 8'($urandom); repeat (3) @(negedge clk); end
        4: begin
             repeat (3) @(negedge clk);
             rd_byte(7'h03, v);
             chk("R7 read rand", 32'(v), 32'(exp_pins(m_dir, m_dat, ext)));
           end
        default: begin
             logic [6:0] a;
             a = 7'($urandom_range(4, 127));
             if ($urandom_range(0, 1) == 0) begin
               rd_byte(a, v);
               chk("R8 read rand", 32'(v), 32'h0);
             end else begin
               wr_byte(a, 8'($urandom));
               chk("R9 word rand", 32'(word), 32'(m_word));
               chk("R9 oe rand", 32'(poe), 32'(m_dir));
             end
           end
      endcase
      chk("R6 pad oe model", 32'(poe), 32'(m_dir));
    end

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule